// File: doc/BRIEF.md
# Constrained Multi-Domain Clock Ratio Controller

This block keeps one 16-bit control word. The word holds six 2-bit divider exponents, one for each clock domain: peripheral, LCD, processor, DSP, traffic controller and DSP memory-management unit. A domain with exponent e runs at the parent rate divided by 2^e.

Every value that enters the word passes through a fixed chain of clamps. The chain keeps the ordering rules between domains true at all times. The stored word then drives six clock-enable pulse trains. These come from one shared 3-bit phase counter, so all domains line up on the divide-by-8 boundary.

Software has two ways to change the word. It can write the whole word at once. It can also send a rate request for one domain, giving a parent rate and a target rate. The block turns the request into an exponent, merges it into the field for that domain and clamps the result. If no exponent can meet the target, the block rejects the request.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: A 3-bit phase counter resets to 0 and advances by one every cycle. A domain's enable is high exactly when the low e bits of the phase are zero, where e is its active exponent. When the phase is 0, all six enables are high.
- R2: The fields of the word are placed as follows: peripheral [1:0], LCD [3:2], processor [5:4], DSP [7:6], traffic controller [9:8], DSP-MMU [11:10]. The word on `cfg_q` changes in the cycle after the write. Bits [15:12] of the written value are stored unchanged.
- R3: The DSP-MMU exponent is first raised to at least the DSP exponent. It is then lowered to at most the DSP exponent plus one.
- R4: After R3, the traffic-controller exponent is raised to at least the processor exponent. It is then raised to at least the clamped DSP-MMU exponent.
- R5: The LCD and peripheral exponents are each raised to at least the final traffic-controller exponent. The processor and DSP exponents are stored exactly as given.
- R6: A stored word becomes active only at the clock edge where the phase goes from 7 to 0. Between those edges the enable pattern keeps the previous word.
- R7: A rate request names a domain with `req_dom`, coded 0 peripheral, 1 LCD, 2 processor, 3 DSP, 4 traffic controller, 5 DSP-MMU. The block picks the smallest e from 0 to 3 for which `req_parent >> e` is at or below `req_target`. It writes e into that field, applies the clamps of R3 to R5, and the result appears on `cfg_q` one cycle later.
- R8: A request is rejected when no such e exists, or when `req_dom` is 6 or 7. In that case `req_reject` is high for exactly the one following cycle and `cfg_q` stays unchanged.
- R9: If a write and a request arrive in the same cycle, the write is stored. The request is dropped and `req_reject` stays low.
- R10: After reset the word is zero, so every domain enable is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Full control-word write strobe |
| wr_data | input | 16 | Control word to write |
| req_en | input | 1 | Rate request strobe |
| req_dom | input | 3 | Domain the request targets |
| req_parent | input | RATE_W | Parent rate for the request |
| req_target | input | RATE_W | Highest acceptable domain rate |
| cfg_q | output | 16 | Stored, clamped control word |
| req_reject | output | 1 | One-cycle flag for a rejected request |
| dom_en | output | 6 | Per-domain clock enables, bit index equals domain code |

## Verification
A full write and a rate request can arrive in the same cycle. The bench provokes this twice: once with a request that would be accepted, and once with a request that would be rejected. Each time it checks that the stored word equals the clamped write value and that the reject flag stays low.

A write can also land partway through the phase cycle. The bench checks the enable pattern phase by phase. The old pattern must hold until the 7-to-0 edge, and the new pattern must take over from there.

// File: rtl/clk_ratio_ctrl.sv
`timescale 1ns/1ps
module clk_ratio_ctrl #(
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              req_en,
  input  logic [2:0]        req_dom,
  input  logic [RATE_W-1:0] req_parent,
  input  logic [RATE_W-1:0] req_target,
  output logic [15:0]       cfg_q,
  output logic              req_reject,
  output logic [5:0]        dom_en
);
  localparam int NDOM  = 6;
  localparam int EXP_W = 2;
  localparam int PH_W  = 3;
  localparam int NEXP  = 1 << EXP_W;

  logic [PH_W-1:0] ph;
  logic [15:0]     act;
  logic [EXP_W-1:0] req_exp;
  logic            req_fit;
  logic            req_ok;
  logic [15:0]     merged;

  function automatic logic [15:0] clamp(input logic [15:0] v);
    logic [1:0] per, lcd, cpu, dsp, tc, mmu;
    logic [2:0] dsp_p1;
    per = v[1:0];
    lcd = v[3:2];
    cpu = v[5:4];
    dsp = v[7:6];
    tc  = v[9:8];
    mmu = v[11:10];
    dsp_p1 = {1'b0, dsp} + 3'd1;
    if (mmu < dsp) mmu = dsp;
    if ({1'b0, mmu} > dsp_p1) mmu = dsp_p1[1:0];
    if (tc < cpu) tc = cpu;
    if (tc < mmu) tc = mmu;
    if (lcd < tc) lcd = tc;
    if (per < tc) per = tc;
    return {v[15:12], mmu, tc, dsp, cpu, lcd, per};
  endfunction

  always_comb begin
    req_exp = '0;
    req_fit = 1'b0;
    for (int e = NEXP - 1; e >= 0; e--) begin
      if ((req_parent >> e) <= req_target) begin
        req_exp = EXP_W'(e);
        req_fit = 1'b1;
      end
    end
  end

  assign req_ok = req_fit && (req_dom < 3'(NDOM));

  always_comb begin
    merged = cfg_q;
    merged[{req_dom, 1'b0} +: EXP_W] = req_exp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph         <= '0;
      cfg_q      <= '0;
      act        <= '0;
      req_reject <= 1'b0;
    end else begin
      ph         <= ph + 1'b1;
      req_reject <= 1'b0;
      if (wr_en)
        cfg_q <= clamp(wr_data);
      else if (req_en) begin
        if (req_ok) cfg_q <= clamp(merged);
        else        req_reject <= 1'b1;
      end
      if (ph == '1) act <= cfg_q;
    end
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_en
    logic [EXP_W-1:0] e;
    assign e = act[EXP_W*d +: EXP_W];
    assign dom_en[d] = ((ph & ((PH_W'(1) << e) - PH_W'(1))) == '0);
  end

  a_r1_all_meet: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == '0) |-> (dom_en == '1));

  a_r2_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q[15:12] == $past(wr_data[15:12])));

  a_r3_mmu_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[11:10] >= cfg_q[7:6]) && ({1'b0, cfg_q[11:10]} <= {1'b0, cfg_q[7:6]} + 3'd1));

  a_r4_tc_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[9:8] >= cfg_q[5:4]) && (cfg_q[9:8] >= cfg_q[11:10]));

  a_r5_slow_domains: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[3:2] >= cfg_q[9:8]) && (cfg_q[1:0] >= cfg_q[9:8]));

  a_r5_keep_cpu_dsp: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q[7:4] == $past(wr_data[7:4])));

  a_r6_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != '0) |-> (act == $past(act)));

  a_r8_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> (cfg_q == $past(cfg_q)));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_en) |=> !req_reject);
endmodule

// File: tb/sim_clk_ratio_ctrl.sv
`timescale 1ns/1ps
module sim_clk_ratio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        req_en = 1'b0;
  logic [2:0]  req_dom = '0;
  logic [31:0] req_parent = '0;
  logic [31:0] req_target = '0;
  logic [15:0] cfg_q;
  logic        req_reject;
  logic [5:0]  dom_en;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  logic [15:0] cur = '0;
  logic [2:0]  ph;

  always #2.5 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) ph <= '0; else ph <= ph + 3'd1;

  clk_ratio_ctrl #(.RATE_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .req_en(req_en), .req_dom(req_dom), .req_parent(req_parent),
    .req_target(req_target), .cfg_q(cfg_q), .req_reject(req_reject),
    .dom_en(dom_en)
  );

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] x);
    n_vec++;
    if (a !== x) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, x);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [15:0] ref_clamp(logic [15:0] v);
    int f[6];
    logic [15:0] r;
    for (int i = 0; i < 6; i++) f[i] = (v >> (2 * i)) & 3;
    f[5] = imax(f[5], f[3]);
    if (f[5] > f[3] + 1) f[5] = f[3] + 1;
    f[4] = imax(imax(f[4], f[2]), f[5]);
    f[1] = imax(f[1], f[4]);
    f[0] = imax(f[0], f[4]);
    r = v & 16'hF000;
    for (int i = 0; i < 6; i++) r = r | 16'(f[i] << (2 * i));
    return r;
  endfunction

  function automatic int ref_exp(logic [31:0] p, logic [31:0] t);
    for (int e = 0; e < 4; e++) if ((p >> e) <= t) return e;
    return -1;
  endfunction

  function automatic logic [5:0] ref_en(logic [15:0] w, logic [2:0] p);
    logic [5:0] r;
    for (int d = 0; d < 6; d++) begin
      int e = (w >> (2 * d)) & 3;
      r[d] = ((p % (1 << e)) == 0);
    end
    return r;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur = '0;
    @(negedge clk);
    chk("R10 cfg after reset", cfg_q, 0);
    chk("R10 reject after reset", req_reject, 0);
    for (int i = 0; i < 8; i++) begin
      chk("R10 all enables", dom_en, 6'h3f);
      @(negedge clk);
    end
  endtask

  task automatic t_write(input string tag, input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    cur = ref_clamp(v);
    chk(tag, cfg_q, cur);
    chk("R5 cpu/dsp kept", cfg_q[7:4], v[7:4]);
    chk("R2 upper bits", cfg_q[15:12], v[15:12]);
  endtask

  task automatic t_apply(input logic [15:0] v);
    logic [15:0] old;
    repeat (9) @(negedge clk);
    while (ph != 3'd1) @(negedge clk);
    old = cur;
    t_write("R2 apply write", v);
    while (ph != 3'd0) begin
      chk("R6 old pattern held", dom_en, ref_en(old, ph));
      @(negedge clk);
    end
    for (int i = 0; i < 16; i++) begin
      chk("R1 new pattern", dom_en, ref_en(cur, ph));
      @(negedge clk);
    end
  endtask

  task automatic t_req(input logic [2:0] d, input logic [31:0] p, input logic [31:0] t);
    int e;
    logic [15:0] m;
    e = ref_exp(p, t);
    req_en = 1'b1; req_dom = d; req_parent = p; req_target = t;
    @(negedge clk);
    req_en = 1'b0;
    if (e < 0 || d > 3'd5) begin
      chk("R8 reject raised", req_reject, 1);
      chk("R8 cfg unchanged", cfg_q, cur);
      @(negedge clk);
      chk("R8 reject one cycle", req_reject, 0);
    end else begin
      m = cur;
      m[2 * d +: 2] = 2'(e);
      cur = ref_clamp(m);
      chk("R7 merged cfg", cfg_q, cur);
      chk("R7 no reject", req_reject, 0);
    end
  endtask

  task automatic t_collide(input logic [15:0] v, input logic [31:0] t);
    wr_en = 1'b1; wr_data = v;
    req_en = 1'b1; req_dom = 3'd2; req_parent = 32'd100; req_target = t;
    @(negedge clk);
    wr_en = 1'b0; req_en = 1'b0;
    cur = ref_clamp(v);
    chk("R9 write wins", cfg_q, cur);
    chk("R9 no reject", req_reject, 0);
  endtask

  initial begin
    t_reset();
    t_write("R3 dsp raises mmu", 16'hF0C0);
    t_write("R3 mmu capped", 16'h0C00);
    t_write("R4 tc from cpu", 16'h0030);
    t_write("R4 tc from mmu", 16'h0440);
    t_write("R5 slow domains", 16'h0100);
    t_write("R2 mixed value", 16'hA5A5);
    t_write("R2 zero", 16'h0000);
    t_apply(16'h3DB6);
    t_apply(16'h0000);
    t_apply(16'h0F5F);
    t_write("R2 clear", 16'h0000);
    t_req(3'd2, 32'd100, 32'd30);
    t_req(3'd0, 32'd100, 32'd100);
    t_req(3'd3, 32'd100, 32'd60);
    t_req(3'd1, 32'd100, 32'd10);
    t_req(3'd6, 32'd100, 32'd100);
    t_req(3'd5, 32'd80, 32'd10);
    t_collide(16'h1234, 32'd100);
    t_collide(16'h4321, 32'd1);
    t_reset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule